// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block turns one request into a series of word transfers. A request names a set of registers (a bit mask), a base address, one of four addressing modes, a direction flag (load or store) and a writeback enable. The sequencer then emits one transfer per selected register. Each transfer carries the register number, the word address and a valid strobe, and it waits on a ready handshake from the memory side. The register file and the memory port are outside the block. When the last transfer has been accepted, the block pulses done and presents the updated base value. A writeback strobe marks the cycles in which that value is to be written back.

Registers always go out in ascending number order to ascending addresses. The mode only sets where the block of words sits relative to the base and which way the base moves. In the two increment modes the block lies at or just above the base. In the two decrement modes it lies at or just below the base. The "before" variants shift the block by one word. A single request therefore replaces a run of individually indexed word transfers.

Top module: `mxfer_seq`

## Requirements
- R1: After reset, xfer_valid, busy, done and wb_strobe are all low.
- R2: Mode code 2'b00 (increment, after) puts the first transfer at base. Mode code 2'b01 (increment, before) puts it at base+4.
- R3: Mode code 2'b11 (decrement, before) puts the lowest transfer at base-4*N, where N is the number of set mask bits. Mode code 2'b10 (decrement, after) puts it at base-4*N+4. Address arithmetic wraps modulo 2^32.
- R4: Transfers carry the set mask bits in ascending register number, and each accepted transfer is followed by an address exactly 4 higher.
- R5: While xfer_valid is high and xfer_ready is low, xfer_valid, xfer_reg and xfer_addr hold their values.
- R6: xfer_is_load equals the is_load value captured at start for every transfer of the sequence.
- R7: With wb_en set and N>0, the done cycle shows wb_strobe high and final_base = base+4*N for increment modes or base-4*N for decrement modes.
- R8: With wb_en clear, the done cycle shows wb_strobe low and final_base equal to base.
- R9: An all-zero mask produces no transfer and no writeback strobe, and done is high in the cycle right after the start edge.
- R10: done is high for exactly the one cycle after the last transfer is accepted, and xfer_valid is low in that cycle.
- R11: A start pulse while busy is high has no effect on the running sequence.
- R12: A start given during the done cycle is accepted and begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when busy is low |
| base_addr | input | 32 | Base byte address |
| reg_mask | input | 16 | Register select mask, bit i selects register i |
| mode | input | 2 | Addressing mode code (see R2, R3) |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_en | input | 1 | Request base writeback |
| xfer_valid | output | 1 | Transfer presented |
| xfer_ready | input | 1 | Memory side accepts the transfer |
| xfer_reg | output | 4 | Register number of the transfer |
| xfer_addr | output | 32 | Word address of the transfer |
| xfer_is_load | output | 1 | Direction of the transfer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_strobe | output | 1 | Write final_base back to the base register |
| final_base | output | 32 | Updated base value, meaningful when done is high |

## Verification
The done pulse of one sequence and the acceptance of the next start can land in the same cycle. This is the tightest back-to-back case. The bench provokes it by raising start in the very cycle in which it first sees done, chaining one populated mask into another and then into an empty mask. It judges the result by the scoreboard drawing the second sequence's transfers in order with no gap or duplicate, and by the empty request's done arriving one cycle later with the correct final base.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'b00,
        AM_INC_BEFORE = 2'b01,
        AM_DEC_AFTER  = 2'b10,
        AM_DEC_BEFORE = 2'b11
    } addr_mode_e;

    function automatic logic mode_is_dec(input addr_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_is_before(input addr_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/mxfer_popcount.sv
module mxfer_popcount #(
    parameter int WIDTH = 16,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + {{(CNT_W-1){1'b0}}, vec[i]};
        end
    end
endmodule

// File: rtl/mxfer_lowest_set.sv
module mxfer_lowest_set #(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [WIDTH-1:0] onehot,
    output logic [IDX_W-1:0] idx
);
    // isolate lowest set bit
    assign onehot = vec & (~vec + {{(WIDTH-1){1'b0}}, 1'b1});

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (onehot[i]) begin
                idx = idx | i[IDX_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mxfer_addr_plan.sv
module mxfer_addr_plan
    import mxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4,
    localparam int STEP_SH   = $clog2(WORD_BYTES)
) (
    input  logic [ADDR_W-1:0] base,
    input  addr_mode_e        mode,
    input  logic [CNT_W-1:0]  count,
    input  logic              wb_en,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_base
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] low_block;
    logic [ADDR_W-1:0] moved_base;

    assign span = {{(ADDR_W-CNT_W){1'b0}}, count} << STEP_SH;

    always_comb begin
        if (mode_is_dec(mode)) begin
            low_block  = base - span;
            moved_base = base - span;
        end else begin
            low_block  = base;
            moved_base = base + span;
        end
        // "before" in increment mode skips the base word;
        // "after" in decrement mode includes the base word
        if (mode_is_dec(mode) != mode_is_before(mode)) begin
            first_addr = low_block + STEP;
        end else begin
            first_addr = low_block;
        end
        final_base = wb_en ? moved_base : base;
    end
endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
    import mxfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int CNT_W     = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NUM_REGS-1:0] reg_mask,
    input  logic [1:0]        mode,
    input  logic              is_load,
    input  logic              wb_en,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [IDX_W-1:0]  xfer_reg,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_is_load,
    output logic              busy,
    output logic              done,
    output logic              wb_strobe,
    output logic [ADDR_W-1:0] final_base
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic                busy;
        logic [NUM_REGS-1:0] mask;
        logic [ADDR_W-1:0]   addr;
        logic                load;
        logic                wb_pend;
        logic                done;
        logic                wb;
        logic [ADDR_W-1:0]   fbase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [CNT_W-1:0]    req_count;
    logic [ADDR_W-1:0]   req_first;
    logic [ADDR_W-1:0]   req_final;
    logic [NUM_REGS-1:0] cur_onehot;
    logic [IDX_W-1:0]    cur_idx;
    logic [NUM_REGS-1:0] mask_left;

    mxfer_popcount #(.WIDTH(NUM_REGS)) cnt_i (
        .vec   (reg_mask),
        .count (req_count)
    );

    mxfer_addr_plan #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) plan_i (
        .base       (base_addr),
        .mode       (addr_mode_e'(mode)),
        .count      (req_count),
        .wb_en      (wb_en),
        .first_addr (req_first),
        .final_base (req_final)
    );

    mxfer_lowest_set #(.WIDTH(NUM_REGS)) scan_i (
        .vec    (st_q.mask),
        .onehot (cur_onehot),
        .idx    (cur_idx)
    );

    assign mask_left = st_q.mask & ~cur_onehot;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wb   = 1'b0;
        if (st_q.busy) begin
            if (xfer_ready) begin
                st_d.mask = mask_left;
                st_d.addr = st_q.addr + STEP;
                if (mask_left == '0) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.wb   = st_q.wb_pend;
                end
            end
        end else if (start) begin
            st_d.mask    = reg_mask;
            st_d.addr    = req_first;
            st_d.load    = is_load;
            st_d.fbase   = req_final;
            st_d.wb_pend = wb_en && (reg_mask != '0);
            if (reg_mask == '0) begin
                st_d.done  = 1'b1;
                st_d.fbase = base_addr;
            end else begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xfer_valid   = st_q.busy;
    assign xfer_reg     = cur_idx;
    assign xfer_addr    = st_q.addr;
    assign xfer_is_load = st_q.load;
    assign busy         = st_q.busy;
    assign done         = st_q.done;
    assign wb_strobe    = st_q.wb;
    assign final_base   = st_q.fbase;

endmodule

// File: rtl/mxfer_seq_chk.sv
module mxfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [IDX_W-1:0]  xfer_reg,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              xfer_is_load,
    input logic              done,
    input logic              wb_strobe
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_reg));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready |=> !xfer_valid || (xfer_addr == $past(xfer_addr) + ADDR_W'(4)));

    // R4
    reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && xfer_ready |=> !xfer_valid || (xfer_reg > $past(xfer_reg)));

    // R6
    load_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && $past(xfer_valid) |-> $stable(xfer_is_load));

    // R7
    wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe |-> done);

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_valid) |-> done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xfer_valid);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && start |=> xfer_valid || done);
endmodule

bind mxfer_seq mxfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .xfer_valid   (xfer_valid),
    .xfer_ready   (xfer_ready),
    .xfer_reg     (xfer_reg),
    .xfer_addr    (xfer_addr),
    .xfer_is_load (xfer_is_load),
    .done         (done),
    .wb_strobe    (wb_strobe)
);

// File: tb/mxfer_seq_tb_top.sv
module mxfer_seq_tb_top;

    typedef struct {
        logic [3:0]  r;
        logic [31:0] a;
        logic        ld;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_mask = '0;
    logic [1:0]  mode = '0;
    logic        is_load = 1'b0;
    logic        wb_en = 1'b0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b1;
    logic [3:0]  xfer_reg;
    logic [31:0] xfer_addr;
    logic        xfer_is_load;
    logic        busy;
    logic        done;
    logic        wb_strobe;
    logic [31:0] final_base;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_hs = -10;
    bit rdy_rand = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    item_t exp_q[$];
    logic [31:0] exp_final;
    logic        exp_wb;
    int          exp_n;
    bit          stall_seen = 1'b0;
    logic [31:0] stall_addr;
    logic [3:0]  stall_reg;

    always #4 clk = ~clk;

    mxfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .reg_mask(reg_mask), .mode(mode), .is_load(is_load), .wb_en(wb_en),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
        .xfer_addr(xfer_addr), .xfer_is_load(xfer_is_load), .busy(busy),
        .done(done), .wb_strobe(wb_strobe), .final_base(final_base)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ready pattern, driven just after the edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        xfer_ready = rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // monitor: pops the scoreboard on each handshake
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (stall_seen && xfer_valid) begin
                check(xfer_addr == stall_addr && xfer_reg == stall_reg, "R5",
                      "held transfer", xfer_addr, stall_addr);
            end
            stall_seen = xfer_valid && !xfer_ready;
            stall_addr = xfer_addr;
            stall_reg  = xfer_reg;
            if (xfer_valid && xfer_ready) begin
                last_hs = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected transfer", xfer_addr, 32'h0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(xfer_reg == e.r, "R4", "register order", {28'h0, xfer_reg}, {28'h0, e.r});
                    check(xfer_addr == e.a, "R2/R3 R4", "address", xfer_addr, e.a);
                    check(xfer_is_load == e.ld, "R6", "direction", {31'h0, xfer_is_load}, {31'h0, e.ld});
                end
            end
        end
    end

    // driver: build expected items, then pulse start (called at negedge+1)
    task automatic launch(input logic [31:0] b, input logic [15:0] m,
                          input logic [1:0] md, input logic ld, input logic wb);
        int n;
        logic [31:0] a;
        n = 0;
        for (int i = 0; i < 16; i++) n += m[i];
        case (md)
            2'b00: a = b;
            2'b01: a = b + 32'd4;
            2'b10: a = b - 32'(4 * n) + 32'd4;
            default: a = b - 32'(4 * n);
        endcase
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                item_t it;
                it.r = 4'(i);
                it.a = a;
                it.ld = ld;
                exp_q.push_back(it);
                a = a + 32'd4;
            end
        end
        exp_n = n;
        exp_wb = wb && (n > 0);
        if (exp_wb) exp_final = md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
        else exp_final = b;
        base_addr = b; reg_mask = m; mode = md; is_load = ld; wb_en = wb;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag, input bit pulse_chk);
        int waited;
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            #1;
            waited++;
        end
        check(done, "R10", {tag, " done seen"}, {31'h0, done}, 32'h1);
        check(!xfer_valid, "R10", {tag, " valid low at done"}, {31'h0, xfer_valid}, 32'h0);
        check(exp_q.size() == 0, "R10", {tag, " all transfers before done"},
              32'(exp_q.size()), 32'h0);
        if (exp_n > 0) begin
            check(last_hs == cyc - 1, "R10", {tag, " done one cycle after last accept"},
                  32'(cyc - last_hs), 32'h1);
        end else begin
            check(waited == 0, "R9", {tag, " empty done next cycle"}, 32'(waited), 32'h0);
        end
        check(final_base == exp_final, exp_wb ? "R7" : "R8", {tag, " final base"},
              final_base, exp_final);
        check(wb_strobe == exp_wb, exp_wb ? "R7" : "R8 R9", {tag, " writeback strobe"},
              {31'h0, wb_strobe}, {31'h0, exp_wb});
        if (pulse_chk) begin
            @(negedge clk);
            #1;
            check(!done, "R10", {tag, " done single cycle"}, {31'h0, done}, 32'h0);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(!xfer_valid && !busy && !done && !wb_strobe, "R1", "reset outputs",
              {28'h0, xfer_valid, busy, done, wb_strobe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R2 increment-after, store, writeback
        launch(32'h0000_1000, 16'h00F0, 2'b00, 1'b0, 1'b1);
        wait_done("IA", 1'b1);

        // R2 increment-before, load, writeback, stalls
        rdy_rand = 1'b1;
        launch(32'h0000_2000, 16'h8001, 2'b01, 1'b1, 1'b1);
        wait_done("IB", 1'b1);

        // R3 decrement-after, store, writeback
        launch(32'h0000_3000, 16'h0F00, 2'b10, 1'b0, 1'b1);
        wait_done("DA", 1'b1);

        // R3 decrement-before, full mask, load, no writeback (R8)
        launch(32'h0000_4000, 16'hFFFF, 2'b11, 1'b1, 1'b0);
        wait_done("DB full", 1'b1);

        // R8 increment-after without writeback
        launch(32'h0000_5000, 16'h0A5A, 2'b00, 1'b1, 1'b0);
        wait_done("IA nowb", 1'b1);

        // R3 wrap below zero, single register then pair
        launch(32'h0000_0000, 16'h0001, 2'b11, 1'b0, 1'b1);
        wait_done("DB single", 1'b1);
        launch(32'h0000_0004, 16'h0003, 2'b11, 1'b1, 1'b1);
        wait_done("DB wrap", 1'b1);

        // R9 empty mask with writeback requested
        launch(32'h0000_6000, 16'h0000, 2'b01, 1'b0, 1'b1);
        wait_done("empty", 1'b1);

        // R11 start while busy is ignored
        launch(32'h0000_7000, 16'h7E00, 2'b10, 1'b0, 1'b1);
        @(negedge clk); #1;
        check(busy, "R11", "busy before stray start", {31'h0, busy}, 32'h1);
        base_addr = 32'hDEAD_0000; reg_mask = 16'h0003; mode = 2'b00; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done("busy ignore R11", 1'b1);

        // R12 back-to-back: start in the done cycle, chained twice
        launch(32'h0000_8000, 16'h0C03, 2'b01, 1'b1, 1'b1);
        wait_done("chain A", 1'b0);
        launch(32'h0000_9000, 16'h1111, 2'b11, 1'b0, 1'b1);
        wait_done("chain B R12", 1'b0);
        launch(32'h0000_A000, 16'h0000, 2'b00, 1'b1, 1'b0);
        wait_done("chain empty R12", 1'b1);

        rdy_rand = 1'b0;
        launch(32'hFFFF_FFF8, 16'h0006, 2'b00, 1'b1, 1'b1);
        wait_done("IA wrap", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule